// File: doc/BRIEF.md
# Speculative Load Queue with Coherence Snoop Replay

This block tracks every load of an out-of-order core from dispatch until it retires, so that the core can keep sequential consistency while loads run ahead of older ones. The front end allocates one entry per load in program order. When the load executes, the block records the cache line that the load read. Every write or ownership upgrade from another core that the cache observes is presented as a snoop. The snoop is checked against the recorded lines of all loads that have already executed and not yet retired.

A load whose line was taken away by remote traffic may have returned a value that no global interleaving allows. Such a load is marked. When a marked load becomes the oldest entry and the core retires it, the block raises a flush request in that same cycle. The whole queue is then emptied, and the load refetches together with everything after it. Loads that have not executed yet cannot be marked, because they will still read fresh data.

The queue is a circular buffer with a head pointer, a tail pointer and an occupancy count. Its depth, the address width and the line offset width are parameters. Execution, the cache and flush recovery belong to the surrounding core.

Top module: `lq_snoop_replay`

## Requirements
- R1: Each accepted allocation takes the slot shown on `alloc_idx_o` that cycle. Successive allocations get consecutive slot numbers, which wrap from DEPTH-1 to 0. `head_valid_o` is high whenever at least one entry is held.
- R2: While DEPTH entries are held, `alloc_ready_o` is low and an allocation request is ignored. The slot index and the queue contents stay unchanged.
- R3: An execute on a held slot records bits [ADDR_W-1:LINE_OFF_W] of its address as that load's line. An execute on a slot that holds no load has no effect.
- R4: A snoop marks every held, executed entry whose recorded line equals the snoop's line. Address bits below LINE_OFF_W (6 by default) are ignored. An entry whose line differs is not marked.
- R5: A snoop never marks an entry that has not yet executed.
- R6: An execute and a matching snoop to the same slot in the same cycle leave that entry marked.
- R7: `head_replay_o` shows the mark of the oldest held entry. It is low when the queue is empty.
- R8: A commit of an unmarked oldest entry removes only that entry and keeps `flush_o` low. The next entry becomes the oldest.
- R9: A commit of a marked oldest entry raises `flush_o` in that same cycle. From the next cycle on, the queue is empty and the next allocation reuses the slot that the flushed load held.
- R10: In a cycle where `flush_o` is high, `alloc_ready_o` is low and an allocation request is dropped.
- R11: After reset the queue is empty, `alloc_idx_o` is 0, `alloc_ready_o` is high, and `head_replay_o` and `flush_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Request to allocate an entry for the next load in program order |
| alloc_ready_o | output | 1 | An allocation is accepted this cycle |
| alloc_idx_o | output | $clog2(DEPTH) | Slot given to the allocation this cycle |
| exec_valid_i | input | 1 | A load executed this cycle |
| exec_idx_i | input | $clog2(DEPTH) | Slot of the executed load |
| exec_addr_i | input | ADDR_W | Address read by the executed load |
| snoop_valid_i | input | 1 | A remote write or upgrade was observed |
| snoop_addr_i | input | ADDR_W | Address of the observed remote write or upgrade |
| commit_valid_i | input | 1 | The oldest load retires this cycle |
| head_valid_o | output | 1 | At least one entry is held |
| head_replay_o | output | 1 | The oldest entry carries a replay mark |
| flush_o | output | 1 | The retiring load must replay; the pipeline must flush |

## Verification
If a compare or a mark bit goes wrong inside the queue, nothing shows at the ports until the affected load becomes the oldest. At that point `head_replay_o` and then `flush_o` are wrong. The delay can be as long as the whole queue draining, so the stimulus commits marked and unmarked loads at several queue depths. A pointer or count fault shows up more quickly. It appears on `alloc_idx_o` and `alloc_ready_o` at the next allocation, or on `head_valid_o` in the cycle after a flush or a pop.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // Per-entry status bits held for every queue slot.
    typedef struct packed {
        logic valid;   // slot holds a load not yet retired
        logic exec;    // the load has executed and its line is recorded
        logic mark;    // remote traffic hit the line; replay at retire
    } lq_flags_t;

endpackage

// File: rtl/lq_ring_ptr.sv
module lq_ring_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] next_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_comb begin
        if (ptr_i == LAST) next_o = '0;
        else               next_o = ptr_i + 1'b1;
    end
endmodule

// File: rtl/lq_line_cmp.sv
module lq_line_cmp #(
    parameter int LINE_W = 26
) (
    input  logic              ent_valid_i,
    input  logic              ent_exec_i,
    input  logic [LINE_W-1:0] ent_line_i,
    input  logic              exec_here_i,
    input  logic [LINE_W-1:0] exec_line_i,
    input  logic              snoop_valid_i,
    input  logic [LINE_W-1:0] snoop_line_i,
    output logic              hit_o
);
    logic old_hit;
    logic new_hit;

    always_comb begin
        old_hit = ent_exec_i && (ent_line_i == snoop_line_i);
        new_hit = exec_here_i && (exec_line_i == snoop_line_i);
        hit_o   = snoop_valid_i && ent_valid_i && (old_hit || new_hit);
    end
endmodule

// File: rtl/lq_snoop_replay.sv
module lq_snoop_replay #(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    output logic              alloc_ready_o,
    output logic [IDX_W-1:0]  alloc_idx_o,
    input  logic              exec_valid_i,
    input  logic [IDX_W-1:0]  exec_idx_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic              commit_valid_i,
    output logic              head_valid_o,
    output logic              head_replay_o,
    output logic              flush_o
);
    import lq_pkg::*;

    localparam int LINE_W = ADDR_W - LINE_OFF_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        lq_flags_t         f;
        logic [LINE_W-1:0] line;
    } lq_entry_t;

    typedef struct packed {
        lq_entry_t [DEPTH-1:0] ent;
        logic [IDX_W-1:0]      head;
        logic [IDX_W-1:0]      tail;
        logic [CNT_W-1:0]      count;
    } lq_state_t;

    lq_state_t s_q, s_d;

    logic [LINE_W-1:0] exec_line;
    logic [LINE_W-1:0] snoop_line;
    logic [IDX_W-1:0]  head_nx;
    logic [IDX_W-1:0]  tail_nx;
    logic [DEPTH-1:0]  hit;
    logic              do_commit;
    logic              do_alloc;
    lq_entry_t         head_ent;

    assign exec_line  = exec_addr_i[ADDR_W-1:LINE_OFF_W];
    assign snoop_line = snoop_addr_i[ADDR_W-1:LINE_OFF_W];

    lq_ring_ptr #(.DEPTH(DEPTH)) u_head_inc (.ptr_i(s_q.head), .next_o(head_nx));
    lq_ring_ptr #(.DEPTH(DEPTH)) u_tail_inc (.ptr_i(s_q.tail), .next_o(tail_nx));

    // One line comparator per slot; both the stored line and an execute
    // landing in the same cycle are checked against the snoop.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        lq_line_cmp #(.LINE_W(LINE_W)) u_cmp (
            .ent_valid_i   (s_q.ent[g].f.valid),
            .ent_exec_i    (s_q.ent[g].f.exec),
            .ent_line_i    (s_q.ent[g].line),
            .exec_here_i   (exec_valid_i && (exec_idx_i == IDX_W'(g))),
            .exec_line_i   (exec_line),
            .snoop_valid_i (snoop_valid_i),
            .snoop_line_i  (snoop_line),
            .hit_o         (hit[g])
        );
    end

    always_comb begin
        head_ent      = s_q.ent[s_q.head];
        head_valid_o  = (s_q.count != '0);
        head_replay_o = head_valid_o && head_ent.f.mark;
        do_commit     = commit_valid_i && head_valid_o;
        flush_o       = do_commit && head_ent.f.mark;
        alloc_ready_o = (s_q.count != FULL_CNT) && !flush_o;
        alloc_idx_o   = s_q.tail;
        do_alloc      = alloc_valid_i && alloc_ready_o;

        s_d = s_q;

        // record the executed load's line
        if (exec_valid_i && s_q.ent[exec_idx_i].f.valid) begin
            s_d.ent[exec_idx_i].f.exec = 1'b1;
            s_d.ent[exec_idx_i].line   = exec_line;
        end

        // set replay marks from snoop hits
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) s_d.ent[i].f.mark = 1'b1;
        end

        // retire the oldest load, or flush everything on a marked one
        if (do_commit) begin
            if (head_ent.f.mark) begin
                for (int i = 0; i < DEPTH; i++) s_d.ent[i] = '0;
                s_d.tail  = s_q.head;
                s_d.count = '0;
            end else begin
                s_d.ent[s_q.head] = '0;
                s_d.head  = head_nx;
                s_d.count = s_q.count - 1'b1;
            end
        end

        // allocate at the tail
        if (do_alloc) begin
            s_d.ent[s_q.tail]         = '0;
            s_d.ent[s_q.tail].f.valid = 1'b1;
            s_d.tail                  = tail_nx;
            s_d.count                 = s_d.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lq_snoop_replay_chk.sv
module lq_snoop_replay_chk #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic alloc_valid_i,
    input logic alloc_ready_o,
    input logic snoop_valid_i,
    input logic commit_valid_i,
    input logic head_valid_o,
    input logic head_replay_o,
    input logic flush_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // Occupancy as seen from the handshakes alone.
    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (flush_o) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(alloc_valid_i && alloc_ready_o)
                           - CNT_W'(commit_valid_i && head_valid_o);
        end
    end

    // R2
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CNT_W'(DEPTH)) |-> !alloc_ready_o);

    // R1
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid_o == (occ_q != '0));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !head_valid_o);

    // R4
    mark_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_replay_o && !$past(head_replay_o))
            |-> ($past(snoop_valid_i) || $past(commit_valid_i)));
endmodule

bind lq_snoop_replay lq_snoop_replay_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_ready_o  (alloc_ready_o),
    .snoop_valid_i  (snoop_valid_i),
    .commit_valid_i (commit_valid_i),
    .head_valid_o   (head_valid_o),
    .head_replay_o  (head_replay_o),
    .flush_o        (flush_o)
);

// File: tb/lq_snoop_replay_tb.sv
`timescale 1ns/1ps
module lq_snoop_replay_tb;
    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid_i = 1'b0;
    logic          alloc_ready_o;
    logic [IW-1:0] alloc_idx_o;
    logic          exec_valid_i = 1'b0;
    logic [IW-1:0] exec_idx_i = '0;
    logic [AW-1:0] exec_addr_i = '0;
    logic          snoop_valid_i = 1'b0;
    logic [AW-1:0] snoop_addr_i = '0;
    logic          commit_valid_i = 1'b0;
    logic          head_valid_o;
    logic          head_replay_o;
    logic          flush_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lq_snoop_replay #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_OFF_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o),
        .alloc_idx_o(alloc_idx_o),
        .exec_valid_i(exec_valid_i), .exec_idx_i(exec_idx_i), .exec_addr_i(exec_addr_i),
        .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
        .commit_valid_i(commit_valid_i),
        .head_valid_o(head_valid_o), .head_replay_o(head_replay_o), .flush_o(flush_o)
    );

    typedef struct packed {
        logic          al;
        logic          exv;
        logic [IW-1:0] exi;
        logic [AW-1:0] exa;
        logic          snv;
        logic [AW-1:0] sna;
        logic          cm;
        logic          e_rdy;
        logic          e_hv;
        logic          e_rep;
        logic          e_fl;
        logic [IW-1:0] e_idx;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 16;
    // expected outputs are those seen during the vector's cycle, before its edge
    localparam vec_t VECS [NV] = '{
        // al exv exi exa           snv sna           cm  rdy hv rep fl idx rq
        '{1'b1,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd11}, // R11 R1 first slot
        '{1'b1,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b1,1'b0,1'b0,2'd1,4'd1},  // R1
        '{1'b1,1'b1,2'd0,32'h1000,  1'b0,32'h0,     1'b0, 1'b1,1'b1,1'b0,1'b0,2'd2,4'd3},  // R3
        '{1'b1,1'b1,2'd1,32'h2040,  1'b1,32'h1030,  1'b0, 1'b1,1'b1,1'b0,1'b0,2'd3,4'd4},  // R4 same line, other offset
        '{1'b1,1'b0,2'd0,32'h0,     1'b1,32'h2000,  1'b0, 1'b0,1'b1,1'b1,1'b0,2'd0,4'd2},  // R2 full, R1 wrap, R7
        '{1'b0,1'b0,2'd0,32'h0,     1'b1,32'h207F,  1'b0, 1'b0,1'b1,1'b1,1'b0,2'd0,4'd2},  // R2 idx held
        '{1'b0,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b1, 1'b0,1'b1,1'b1,1'b1,2'd0,4'd9},  // R9 flush
        '{1'b0,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd9},  // R9 empty, slot reused
        '{1'b1,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd1},  // R1
        '{1'b1,1'b0,2'd0,32'h0,     1'b1,32'h5000,  1'b0, 1'b1,1'b1,1'b0,1'b0,2'd1,4'd5},  // R5 unexecuted target
        '{1'b0,1'b1,2'd0,32'h5000,  1'b0,32'h0,     1'b0, 1'b1,1'b1,1'b0,1'b0,2'd2,4'd5},  // R5 still unmarked
        '{1'b0,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b1, 1'b1,1'b1,1'b0,1'b0,2'd2,4'd8},  // R8 clean retire
        '{1'b0,1'b1,2'd1,32'h6000,  1'b1,32'h6010,  1'b0, 1'b1,1'b1,1'b0,1'b0,2'd2,4'd6},  // R6 same-cycle pair
        '{1'b0,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b1,1'b1,1'b0,2'd2,4'd6},  // R6 mark visible
        '{1'b1,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b1, 1'b0,1'b1,1'b1,1'b1,2'd2,4'd10}, // R10 alloc dropped
        '{1'b0,1'b0,2'd0,32'h0,     1'b0,32'h0,     1'b0, 1'b1,1'b0,1'b0,1'b0,2'd1,4'd10}  // R10 R9 tail at slot 1
    };

    task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got {rdy,hv,rep,fl,idx}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {alloc_ready_o, head_valid_o, head_replay_o, flush_o, alloc_idx_o};
    endfunction

    task automatic idle();
        alloc_valid_i  = 1'b0;
        exec_valid_i   = 1'b0;
        snoop_valid_i  = 1'b0;
        commit_valid_i = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        e = 6'b1_0_0_0_00;
        check(outs() == e, "R11", outs(), e);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            alloc_valid_i  = VECS[v].al;
            exec_valid_i   = VECS[v].exv;
            exec_idx_i     = VECS[v].exi;
            exec_addr_i    = VECS[v].exa;
            snoop_valid_i  = VECS[v].snv;
            snoop_addr_i   = VECS[v].sna;
            commit_valid_i = VECS[v].cm;
            #1;
            e = {VECS[v].e_rdy, VECS[v].e_hv, VECS[v].e_rep, VECS[v].e_fl, VECS[v].e_idx};
            check(outs() == e, $sformatf("R%0d vec %0d", VECS[v].rq, v), outs(), e);
        end

        // R3: execute on an empty slot is ignored; a later snoop must not mark it
        @(negedge clk);
        idle();
        exec_valid_i = 1'b1; exec_idx_i = 2'd1; exec_addr_i = 32'h7000;
        @(negedge clk);
        idle();
        alloc_valid_i = 1'b1;                 // slot 1
        @(negedge clk);
        idle();
        snoop_valid_i = 1'b1; snoop_addr_i = 32'h7000;
        @(negedge clk);
        idle();
        #1;
        e = 6'b1_1_0_0_10;
        check(outs() == e, "R3 stale execute", outs(), e);
        // R8: clean retire empties the single entry
        commit_valid_i = 1'b1;
        #1;
        e = 6'b1_1_0_0_10;
        check(outs() == e, "R8 commit cycle", outs(), e);
        @(negedge clk);
        idle();
        #1;
        e = 6'b1_0_0_0_10;
        check(outs() == e, "R8 after pop", outs(), e);

        // R11: reset in mid-operation returns to the empty state
        alloc_valid_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        e = 6'b1_0_0_0_00;
        check(outs() == e, "R11 mid reset", outs(), e);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule